// File: doc/BRIEF.md
# Multiplexed-Bus Clock Register File

This block is the host-facing storage of a real-time clock. A host reaches 64 byte locations over one shared 8-bit address/data bus. Ten bytes hold time and alarm values. Four bytes are control and status locations. The remaining fifty bytes are plain battery-backed RAM.

The host places an address on `ad_i` and drops the address strobe, which latches the low six bits. A data strobe then moves one byte. The direction comes from the read/write line, and chip select must be high. Certain bits are fixed against host writes:
- bit 7 of the seconds byte;
- the status bit at the top of control byte A;
- both status bytes C and D.

A bus-enable input that is low freezes the bus side completely. Separate update logic asserts `upd_win_i` once per second. While it is high, that logic owns the ten time bytes through a private port. In the same window, host reads of those bytes return a fixed filler value and host writes to them are dropped. The update-in-progress flag at bit 7 of byte A is driven from outside by `uip_i`. Timing logic raises it early enough that software seeing it low can read safely.

Top module: `rtc_regfile`

## Requirements
- R1: After reset every stored location reads 0x00. This covers offsets 0–11 and 14–63, with `uip_i` low.
- R2: At a clock edge where `as_i` was high at the previous edge and is low now, with `bus_en_i` high, the address is latched from `ad_i[5:0]`. Bits 7:6 are ignored, and the address holds until the next such edge.
- R3: A write commits at the clock edge where `ds_i` falls, with `rw_i`=0 (1 means read) and `cs_i`=1. The byte is taken from `ad_i` at that edge and goes to the latched offset. Offsets 0–9 are time bytes, 11 is control byte B and 14–63 are RAM, and each reads back what was written.
- R4: `ad_oe_o` is high exactly while `ds_i`, `rw_i`, `cs_i` and `bus_en_i` are all high. While it is high, `ad_o` shows the latched location combinationally. Otherwise `ad_o` is 0x00.
- R5: Bit 7 of the seconds byte (offset 0) is read-only to the host. A host write updates only bits 6:0.
- R6: Offset 10 reads `{uip_i, stored[6:0]}`. Host writes set only bits 6:0.
- R7: Offsets 12 and 13 read `stat_c_i` and `stat_d_i`, and host writes to them change nothing.
- R8: While `upd_win_i` is high, host reads of offsets 0–9 return 0xFF and host writes to offsets 0–9 are dropped. Offsets 10–63 stay fully accessible.
- R9: An engine write stores `eng_wdata_i` at `eng_addr_i` (0–9) only while `upd_win_i` is high; outside it the write is ignored. `eng_rdata_o` always shows the byte at `eng_addr_i`, and is 0x00 for 10–15.
- R10: While `bus_en_i` is low, no address is latched, no write commits and `ad_oe_o` stays low.
- R11: While `cs_i` is low, no write commits and `ad_oe_o` stays low.
- R12: `ctrl_a_o` shows the stored bits 6:0 of byte A, and `ctrl_b_o` shows byte B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus enable; low blocks all bus activity |
| cs_i | input | 1 | Chip select, active high |
| as_i | input | 1 | Address strobe, falling edge latches address |
| ds_i | input | 1 | Data strobe |
| rw_i | input | 1 | 1 = read, 0 = write |
| ad_i | input | 8 | Multiplexed address/data in |
| ad_o | output | 8 | Read data out |
| ad_oe_o | output | 1 | Read data drive enable |
| upd_win_i | input | 1 | Update window, engine owns time bytes |
| uip_i | input | 1 | Update-in-progress flag shown at byte A bit 7 |
| eng_we_i | input | 1 | Engine write strobe |
| eng_addr_i | input | 4 | Engine time-byte index |
| eng_wdata_i | input | 8 | Engine write data |
| eng_rdata_o | output | 8 | Engine read data |
| stat_c_i | input | 8 | Content of status byte C |
| stat_d_i | input | 8 | Content of status byte D |
| ctrl_a_o | output | 7 | Stored writable bits of byte A |
| ctrl_b_o | output | 8 | Stored control byte B |

## Verification
The main traffic has three phases:
- a fill of all 64 offsets with an offset-derived pattern, then a full read-back, which exposes any decode that aliases two locations;
- the same accesses repeated with `upd_win_i` high, which separates locking of time bytes from the still-open control and RAM space;
- writes of all-ones and mixed patterns to the partly read-only bytes, which show whether the fixed bits leak or clobber their writable neighbours.

Accesses with bus enable or chip select low are followed by a data phase with no new address. That phase shows both that the old address survived and that no location changed.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned N_TIME  = 10;
  localparam int unsigned OFS_SEC = 0;
  localparam int unsigned OFS_A   = 10;
  localparam int unsigned OFS_B   = 11;
  localparam int unsigned OFS_C   = 12;
  localparam int unsigned OFS_D   = 13;
  localparam int unsigned OFS_RAM = 14;
  localparam int unsigned N_LOC   = 1 << ADDR_W;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    byte_t             data;
  } host_wr_t;
endpackage

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_regfile_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              cs_i,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  byte_t             ad_i,
  output host_wr_t          wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o
);
  logic              as_q, ds_q;
  logic [ADDR_W-1:0] addr_q;
  logic              as_fall, ds_fall;

  assign as_fall = as_q & ~as_i & bus_en_i;
  assign ds_fall = ds_q & ~ds_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q   <= 1'b0;
      ds_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      as_q <= as_i;
      ds_q <= ds_i;
      if (as_fall) addr_q <= ad_i[ADDR_W-1:0];
    end
  end

  always_comb begin
    wr_o.wr   = ds_fall & ~rw_i & cs_i & bus_en_i;
    wr_o.addr = addr_q;
    wr_o.data = ad_i;
  end

  assign addr_o = addr_q;
  assign rd_o   = ds_i & rw_i & cs_i & bus_en_i;
endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
  import rtc_regfile_pkg::*;
#(
  parameter int unsigned N_BYTES = N_TIME,
  parameter int unsigned ENG_AW  = $clog2(N_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  host_wr_t          hwr_i,
  input  logic              lock_i,
  input  logic              eng_we_i,
  input  logic [ENG_AW-1:0] eng_addr_i,
  input  byte_t             eng_wdata_i,
  output byte_t             bytes_o [N_BYTES]
);
  byte_t time_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic  eng_hit, host_hit;
    byte_t host_val;
    assign eng_hit  = lock_i & eng_we_i & (eng_addr_i == ENG_AW'(g));
    assign host_hit = ~lock_i & hwr_i.wr & (hwr_i.addr == ADDR_W'(g));
    if (g == OFS_SEC) begin : g_ro_msb
      assign host_val = {time_q[g][DATA_W-1], hwr_i.data[DATA_W-2:0]};
    end else begin : g_full
      assign host_val = hwr_i.data;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       time_q[g] <= '0;
      else if (eng_hit)  time_q[g] <= eng_wdata_i;
      else if (host_hit) time_q[g] <= host_val;
    end
    assign bytes_o[g] = time_q[g];
  end
endmodule

// File: rtl/rtc_ram_bank.sv
module rtc_ram_bank
  import rtc_regfile_pkg::*;
#(
  parameter int unsigned BASE  = OFS_RAM,
  parameter int unsigned WORDS = N_LOC - OFS_RAM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  host_wr_t          hwr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output byte_t             rd_data_o
);
  byte_t             ram_q [WORDS];
  logic [ADDR_W-1:0] rd_idx;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ram_q[g] <= '0;
      else if (hwr_i.wr && hwr_i.addr == ADDR_W'(BASE + g)) ram_q[g] <= hwr_i.data;
    end
  end

  assign rd_idx    = rd_addr_i - ADDR_W'(BASE);
  assign rd_data_o = (rd_addr_i >= ADDR_W'(BASE) && rd_idx < ADDR_W'(WORDS)) ? ram_q[rd_idx] : '0;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
#(
  parameter logic [7:0] LOCK_VAL = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_en_i,
  input  logic       cs_i,
  input  logic       as_i,
  input  logic       ds_i,
  input  logic       rw_i,
  input  logic [7:0] ad_i,
  output logic [7:0] ad_o,
  output logic       ad_oe_o,
  input  logic       upd_win_i,
  input  logic       uip_i,
  input  logic       eng_we_i,
  input  logic [3:0] eng_addr_i,
  input  logic [7:0] eng_wdata_i,
  output logic [7:0] eng_rdata_o,
  input  logic [7:0] stat_c_i,
  input  logic [7:0] stat_d_i,
  output logic [6:0] ctrl_a_o,
  output logic [7:0] ctrl_b_o
);
  localparam int unsigned ENG_AW = $clog2(N_TIME);

  host_wr_t          hwr;
  logic [ADDR_W-1:0] host_addr;
  logic              host_rd;
  byte_t             time_b [N_TIME];
  byte_t             ram_rd;
  byte_t             rd_mux;
  byte_t             sec_byte;
  logic [DATA_W-2:0] ctrl_a_q;
  byte_t             ctrl_b_q;

  rtc_bus_if u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_en_i (bus_en_i),
    .cs_i     (cs_i),
    .as_i     (as_i),
    .ds_i     (ds_i),
    .rw_i     (rw_i),
    .ad_i     (ad_i),
    .wr_o     (hwr),
    .addr_o   (host_addr),
    .rd_o     (host_rd)
  );

  rtc_time_bank #(.N_BYTES(N_TIME), .ENG_AW(ENG_AW)) u_time (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hwr_i       (hwr),
    .lock_i      (upd_win_i),
    .eng_we_i    (eng_we_i),
    .eng_addr_i  (eng_addr_i[ENG_AW-1:0]),
    .eng_wdata_i (eng_wdata_i),
    .bytes_o     (time_b)
  );

  rtc_ram_bank #(.BASE(OFS_RAM), .WORDS(N_LOC - OFS_RAM)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hwr_i     (hwr),
    .rd_addr_i (host_addr),
    .rd_data_o (ram_rd)
  );

  // control byte A keeps only its writable low bits; B is a full byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
    end else if (hwr.wr) begin
      if (hwr.addr == ADDR_W'(OFS_A)) ctrl_a_q <= hwr.data[DATA_W-2:0];
      if (hwr.addr == ADDR_W'(OFS_B)) ctrl_b_q <= hwr.data;
    end
  end

  always_comb begin
    if (host_addr < ADDR_W'(N_TIME))
      rd_mux = upd_win_i ? LOCK_VAL : time_b[host_addr[ENG_AW-1:0]];
    else if (host_addr == ADDR_W'(OFS_A)) rd_mux = {uip_i, ctrl_a_q};
    else if (host_addr == ADDR_W'(OFS_B)) rd_mux = ctrl_b_q;
    else if (host_addr == ADDR_W'(OFS_C)) rd_mux = stat_c_i;
    else if (host_addr == ADDR_W'(OFS_D)) rd_mux = stat_d_i;
    else rd_mux = ram_rd;
  end

  assign ad_o        = host_rd ? rd_mux : '0;
  assign ad_oe_o     = host_rd;
  assign eng_rdata_o = (eng_addr_i < 4'(N_TIME)) ? time_b[eng_addr_i[ENG_AW-1:0]] : '0;
  assign ctrl_a_o    = ctrl_a_q;
  assign ctrl_b_o    = ctrl_b_q;
  assign sec_byte    = time_b[OFS_SEC];
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter logic [7:0] LOCK_VAL = 8'hFF
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_en_i,
  input logic       cs_i,
  input logic       as_i,
  input logic       ds_i,
  input logic [7:0] ad_o,
  input logic       ad_oe_o,
  input logic       upd_win_i,
  input logic       uip_i,
  input logic       eng_we_i,
  input logic [7:0] stat_c_i,
  input logic [6:0] ctrl_a_o,
  input logic [7:0] ctrl_b_o,
  input logic [5:0] host_addr,
  input logic [7:0] sec_byte
);
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($fell(as_i) && bus_en_i) |=> $stable(host_addr));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_i |-> !ad_oe_o);
  p_sec_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_win_i |=> $stable(sec_byte[7]));
  p_a_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && host_addr == 6'd10) |-> ad_o[7] == uip_i);
  p_c_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && host_addr == 6'd12) |-> ad_o == stat_c_i);
  p_lock_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && upd_win_i && host_addr < 6'd10) |-> ad_o == LOCK_VAL);
  p_lock_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_win_i && !eng_we_i) |=> $stable(sec_byte));
  p_stby_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |=> $stable(ctrl_b_o));
  p_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(ctrl_a_o));
endmodule

bind rtc_regfile rtc_regfile_chk #(.LOCK_VAL(LOCK_VAL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_en_i  (bus_en_i),
  .cs_i      (cs_i),
  .as_i      (as_i),
  .ds_i      (ds_i),
  .ad_o      (ad_o),
  .ad_oe_o   (ad_oe_o),
  .upd_win_i (upd_win_i),
  .uip_i     (uip_i),
  .eng_we_i  (eng_we_i),
  .stat_c_i  (stat_c_i),
  .ctrl_a_o  (ctrl_a_o),
  .ctrl_b_o  (ctrl_b_o),
  .host_addr (host_addr),
  .sec_byte  (sec_byte)
);

// File: tb/tb_rtc_regfile.sv
module tb_rtc_regfile;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_ni = 0;
  logic       bus_en = 1, cs = 1, as_s = 0, ds = 0, rw = 1;
  logic [7:0] ad = 0;
  logic [7:0] ad_o;
  logic       ad_oe_o;
  logic       upd_win = 0, uip = 0, eng_we = 0;
  logic [3:0] eng_addr = 0;
  logic [7:0] eng_wdata = 0, eng_rdata_o;
  logic [7:0] stat_c = 8'hA5, stat_d = 8'h80;
  logic [6:0] ctrl_a_o;
  logic [7:0] ctrl_b_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_en_i(bus_en), .cs_i(cs), .as_i(as_s),
    .ds_i(ds), .rw_i(rw), .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .upd_win_i(upd_win), .uip_i(uip), .eng_we_i(eng_we), .eng_addr_i(eng_addr),
    .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata_o), .stat_c_i(stat_c),
    .stat_d_i(stat_d), .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_mem [64];
  int m_a, m_b, m_addr;
  bit as_p, ds_p;

  function automatic int m_read(input int a);
    if (a < 10) return upd_win ? 255 : m_mem[a];
    case (a)
      10: return (int'(uip) << 7) | m_a;
      11: return m_b;
      12: return int'(stat_c);
      13: return int'(stat_d);
      default: return m_mem[a];
    endcase
  endfunction

  function automatic string m_tag(input int a);
    if (a < 10 && upd_win) return "R8";
    if (a == 0) return "R5";
    if (a == 10) return "R6";
    if (a == 12 || a == 13) return "R7";
    return "R3";
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_a = 0; m_b = 0; m_addr = 0; as_p = 0; ds_p = 0;
    end else begin
      int na, d;
      na = m_addr;
      d  = int'(ad);
      if (as_p && !as_s && bus_en) na = d & 63;
      if (ds_p && !ds && !rw && cs && bus_en) begin
        if (m_addr < 10) begin
          if (!upd_win) m_mem[m_addr] = (m_addr == 0) ? ((m_mem[0] & 128) | (d & 127)) : d;
        end else if (m_addr == 10) m_a = d & 127;
        else if (m_addr == 11) m_b = d;
        else if (m_addr > 13) m_mem[m_addr] = d;
      end
      if (upd_win && eng_we && eng_addr < 10) m_mem[eng_addr] = int'(eng_wdata);
      as_p = as_s; ds_p = ds; m_addr = na;
    end
  end

  // compare on every clock, after registers settle
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      bit eoe;
      int ed;
      eoe = ds && rw && cs && bus_en;
      ed  = eoe ? m_read(m_addr) : 0;
      chk(ad_oe_o == eoe, "R4", ad_oe_o, eoe);
      chk(int'(ad_o) == ed, eoe ? m_tag(m_addr) : "R4", ad_o, ed);
      chk(int'(eng_rdata_o) == (eng_addr < 10 ? m_mem[eng_addr] : 0), "R9",
          eng_rdata_o, eng_addr < 10 ? m_mem[eng_addr] : 0);
      chk(int'(ctrl_a_o) == m_a, "R12", ctrl_a_o, m_a);
      chk(int'(ctrl_b_o) == m_b, "R12", ctrl_b_o, m_b);
    end
  end

  task automatic addr_phase(input logic [7:0] a);
    @(negedge clk); as_s = 1; ad = a;
    @(negedge clk); as_s = 0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    addr_phase(a);
    @(negedge clk); ad = d; rw = 0; ds = 1;
    @(negedge clk); ds = 0;
    @(negedge clk); ad = 0; rw = 1;
  endtask

  task automatic data_rd(output logic [7:0] d);
    @(negedge clk); rw = 1; ds = 1;
    @(posedge clk); #1 d = ad_o;
    @(negedge clk); ds = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    addr_phase(a);
    data_rd(d);
    chk(d == e, tag, d, e);
  endtask

  task automatic eng_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); eng_we = 1; eng_addr = a; eng_wdata = d;
    @(negedge clk); eng_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd_expect(8'd0, 8'h00, "R1");
    rd_expect(8'd5, 8'h00, "R1");
    rd_expect(8'd11, 8'h00, "R1");
    rd_expect(8'd30, 8'h00, "R1");
    rd_expect(8'd63, 8'h00, "R1");
    // fill and read back every location (R3 via reference)
    for (int a = 0; a < 64; a++) bus_wr(8'(a), 8'((a * 29 + 7) & 255));
    for (int a = 0; a < 64; a++) begin addr_phase(8'(a)); data_rd(d); end
    rd_expect(8'd33, 8'hC4, "R3");
    @(negedge clk);
    chk(ad_oe_o == 1'b0, "R4", ad_oe_o, 0);
    // R5 seconds msb
    upd_win = 1; eng_write(4'd0, 8'h80); upd_win = 0;
    bus_wr(8'd0, 8'h15);
    rd_expect(8'd0, 8'h95, "R5");
    bus_wr(8'd0, 8'h2A);
    rd_expect(8'd0, 8'hAA, "R5");
    // R6 byte A
    bus_wr(8'd10, 8'hFF);
    rd_expect(8'd10, 8'h7F, "R6");
    uip = 1;
    rd_expect(8'd10, 8'hFF, "R6");
    uip = 0;
    // R7 status bytes
    bus_wr(8'd12, 8'h00);
    bus_wr(8'd13, 8'hFF);
    rd_expect(8'd12, 8'hA5, "R7");
    stat_c = 8'h3C;
    rd_expect(8'd12, 8'h3C, "R7");
    rd_expect(8'd13, 8'h80, "R7");
    // R8 update window
    upd_win = 1;
    rd_expect(8'd3, 8'hFF, "R8");
    bus_wr(8'd3, 8'h11);
    bus_wr(8'd40, 8'h66);
    rd_expect(8'd40, 8'h66, "R8");
    eng_write(4'd7, 8'h31);
    upd_win = 0;
    rd_expect(8'd3, 8'h5E, "R8");
    rd_expect(8'd7, 8'h31, "R9");
    // R9 engine write outside window ignored
    eng_write(4'd7, 8'h44);
    rd_expect(8'd7, 8'h31, "R9");
    @(negedge clk); eng_addr = 4'd12;
    @(negedge clk);
    chk(eng_rdata_o == 8'h00, "R9", eng_rdata_o, 0);
    // R10 bus disabled: no latch, no write
    bus_en = 0;
    bus_wr(8'd50, 8'h99);
    bus_en = 1;
    data_rd(d);
    chk(d == 8'h31, "R10", d, 8'h31);
    rd_expect(8'd50, 8'hB1, "R10");
    // R11 chip select low
    cs = 0;
    bus_wr(8'd60, 8'h12);
    bus_wr(8'd11, 8'h00);
    data_rd(d);
    chk(d == 8'h00 && ad_oe_o == 1'b0, "R11", d, 0);
    cs = 1;
    rd_expect(8'd60, 8'hD3, "R11");
    rd_expect(8'd11, 8'h46, "R11");
    chk(ctrl_b_o == 8'h46, "R12", ctrl_b_o, 8'h46);
    // R2 upper address bits ignored
    bus_wr(8'hD4, 8'h5A);
    rd_expect(8'd20, 8'h5A, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule